// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a bitstream into a target FPGA over the target's slave serial configuration pins. A load begins with a one-cycle start command. The block pulls the active-low program pin low for a fixed number of system clocks and then releases it. It then checks that the target's done pin is still low and waits for a fixed latency. After that it shifts the bitstream out most significant bit first, on a serial clock derived from the system clock.

Bytes arrive on a valid/ready stream, and a marker on the final byte closes the stream. Once the final byte has been shifted out, the block keeps sending all-ones filler bytes and looks at done at the end of each one. When done is seen high, it sends one more filler byte and reports success. If done stays low for longer than a programmable bound, the block stops and reports a timeout. A start request that asks for partial reconfiguration is refused and leaves the pins untouched. While no load is running, one output reports whether the target is being held in reset, which is the case when done is low.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, and at any time no load is running, `tgt_prog_n` is 1, `tgt_sclk` is 0, `busy` is 0 and `bs_ready` is 0. Reset also leaves `load_ok` at 0 and `load_err` at 0.
- R2: An accepted start drives `tgt_prog_n` low for exactly `PULSE_CYC` system clocks and then releases it. `tgt_prog_n` is low only while `busy` is 1.
- R3: A start with `start_partial` = 1, given while idle, is refused. `load_err` becomes 3, `busy` stays 0, `tgt_prog_n` never goes low and no serial clock is produced.
- R4: If the synchronised done input is high in the cycle after the program pin is released, the load ends with `load_err` = 1 and no serial clock edges.
- R5: The first rising edge of `tgt_sclk` comes at least `LATENCY_CYC` system clocks after `tgt_prog_n` returns high.
- R6: Each byte goes out most significant bit first. `tgt_sdo` changes only while `tgt_sclk` is low, so the target takes each bit on a rising edge.
- R7: While the stream keeps `bs_valid` high, consecutive rising edges of `tgt_sclk` are exactly `2*DIV_HALF` system clocks apart. This holds across byte boundaries and across the step from the last data byte to the first filler byte.
- R8: If done is high when the last data byte ends, exactly one 0xFF byte follows, and then `load_ok` = 1 and `load_err` = 0.
- R9: If done is low when the last data byte ends, 0xFF bytes follow and done is checked at the end of each one. After the filler byte at whose end done is seen high, exactly one more 0xFF byte is sent and `load_ok` becomes 1.
- R10: A filler byte can end with done still low at a point where at least `tmo_limit` cycles have passed since the last data byte ended. The load then stops with `load_err` = 2, `load_ok` = 0 and no further serial clocks.
- R11: `tgt_in_reset` is 1 exactly when no load is running and the synchronised done input is low, and 0 otherwise.
- R12: A start request that arrives while `busy` is 1 is ignored. The running load completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle request to begin a load |
| start_partial | input | 1 | Start request asks for partial reconfiguration (refused) |
| tmo_limit | input | TMO_W | Completion bound in system clocks, counted from end of data |
| bs_valid | input | 1 | Bitstream byte available |
| bs_data | input | 8 | Bitstream byte |
| bs_last | input | 1 | Marks the final bitstream byte |
| bs_ready | output | 1 | Block takes the byte in this cycle |
| tgt_prog_n | output | 1 | Active-low program pin to the target |
| tgt_sclk | output | 1 | Serial configuration clock |
| tgt_sdo | output | 1 | Serial configuration data |
| tgt_done | input | 1 | Target's done pin (asynchronous) |
| busy | output | 1 | A load is in progress |
| load_ok | output | 1 | Last load finished successfully |
| load_err | output | 2 | 0 none, 1 done high too early, 2 timeout, 3 unsupported request |
| tgt_in_reset | output | 1 | Idle and target done low |

## Verification
The program pin falls on the clock edge that accepts the start and rises `PULSE_CYC` edges later. `load_ok` and `load_err` update on the edge that ends the final filler byte, and `load_err` = 3 appears on the edge right after a refused request. Done passes through a two-flop synchroniser before each byte-end decision, so the bench raises done four bit periods before the byte it should be seen in ends, which leaves a margin of many cycles. The bench drives inputs and reads outputs one nanosecond after the falling clock edge, and it waits for `busy` to fall before it reads any result.

// File: rtl/cfgl_pkg.sv
// Shared types for the serial configuration loader.
// Assumes: error codes are visible at the top-level ports and must keep their values.
package cfgl_pkg;

    // Result codes reported on load_err
    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_EARLY_DONE  = 2'd1,
        ERR_TIMEOUT     = 2'd2,
        ERR_UNSUPPORTED = 2'd3
    } cfgl_err_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_CHECK,
        ST_WAIT,
        ST_DATA,
        ST_POLL,
        ST_FLUSH
    } cfgl_state_e;

    // Filler byte shifted out after the data
    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/cfgl_sync.sv
// Multi-flop synchroniser for the target's done pin.
// Assumes: the input is a slow level signal; STAGES >= 2.
module cfgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff;

    // Shift the raw level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];

endmodule

// File: rtl/cfgl_shifter.sv
// Byte serialiser: shifts each byte MSB first on a divided serial clock.
// Data changes on the falling edge; the target samples on the rising edge.
// A new byte can be loaded on the very cycle that ends the current byte,
// so a steady supply of bytes gives an unbroken clock.
// Assumes: DIV_HALF >= 1 system clocks per serial half period.
module cfgl_shifter #(
    parameter int DIV_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_vld,
    input  logic [7:0] ld_byte,
    output logic       ld_rdy,
    output logic       byte_end,
    output logic       sclk,
    output logic       sdo
);

    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic          active;
    logic          phase;      // 0: clock low half, 1: clock high half
    logic [2:0]    bit_cnt;
    logic [7:0]    sh;
    logic [DW-1:0] div_cnt;
    logic          tick;

    assign tick     = (div_cnt == DW'(DIV_HALF - 1));
    assign byte_end = active && tick && phase && (bit_cnt == 3'd7);
    assign ld_rdy   = !active || byte_end;
    assign sclk     = active && phase;
    assign sdo      = active ? sh[7] : 1'b1;

    // Load a byte, advance the half-period divider, shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= 1'b0;
            bit_cnt <= 3'd0;
            sh      <= 8'hFF;
            div_cnt <= '0;
        end else if (ld_vld && ld_rdy) begin
            active  <= 1'b1;
            phase   <= 1'b0;
            bit_cnt <= 3'd0;
            sh      <= ld_byte;
            div_cnt <= '0;
        end else if (active) begin
            if (tick) begin
                div_cnt <= '0;
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                    end else begin
                        sh      <= {sh[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

endmodule

// File: rtl/cfgl_sequencer.sv
// Load sequencer: program pulse, early-done check, latency wait, data
// streaming, filler clocking with done polling, and timeout.
// Assumes: done_s is already synchronised; the shifter accepts a byte
// whenever ld_rdy is high.
module cfgl_sequencer
    import cfgl_pkg::*;
#(
    parameter int PULSE_CYC   = 100,
    parameter int LATENCY_CYC = 750000,
    parameter int TMO_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             start_partial,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             done_s,
    input  logic             bs_valid,
    input  logic [7:0]       bs_data,
    input  logic             bs_last,
    output logic             bs_ready,
    output logic             ld_vld,
    output logic [7:0]       ld_byte,
    input  logic             ld_rdy,
    input  logic             byte_end,
    output logic             prog_n,
    output logic             busy,
    output logic             load_ok,
    output logic [1:0]       load_err,
    output logic             tgt_in_reset
);

    localparam int CMAX = (PULSE_CYC > LATENCY_CYC) ? PULSE_CYC : LATENCY_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    cfgl_state_e      state;
    cfgl_err_e        err_q;
    logic [CW-1:0]    cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             last_seen;
    logic             tmo_hit;

    assign tmo_hit      = (tmo_cnt >= tmo_limit);
    assign busy         = (state != ST_IDLE);
    assign load_err     = err_q;
    assign tgt_in_reset = (state == ST_IDLE) && !done_s;
    assign bs_ready     = (state == ST_DATA) && !last_seen && ld_rdy;

    // Choose what the shifter is offered: stream bytes or filler
    always_comb begin
        ld_byte = ((state == ST_DATA) && !last_seen) ? bs_data : FILL_BYTE;
        case (state)
            ST_DATA: ld_vld = last_seen ? byte_end : bs_valid;
            ST_POLL: ld_vld = byte_end && (done_s || !tmo_hit);
            default: ld_vld = 1'b0;
        endcase
    end

    // Phase sequencing, counters and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            err_q     <= ERR_NONE;
            load_ok   <= 1'b0;
            prog_n    <= 1'b1;
            cnt       <= '0;
            tmo_cnt   <= '0;
            last_seen <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        load_ok <= 1'b0;
                        if (start_partial) begin
                            err_q <= ERR_UNSUPPORTED;
                        end else begin
                            err_q     <= ERR_NONE;
                            prog_n    <= 1'b0;
                            cnt       <= '0;
                            last_seen <= 1'b0;
                            state     <= ST_PULSE;
                        end
                    end
                end
                ST_PULSE: begin
                    if (cnt == CW'(PULSE_CYC - 1)) begin
                        prog_n <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_CHECK;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_CHECK: begin
                    if (done_s) begin
                        err_q <= ERR_EARLY_DONE;
                        state <= ST_IDLE;
                    end else begin
                        cnt   <= '0;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt == CW'(LATENCY_CYC - 1)) state <= ST_DATA;
                    else                             cnt   <= cnt + CW'(1);
                end
                ST_DATA: begin
                    if (bs_valid && bs_ready && bs_last) last_seen <= 1'b1;
                    if (last_seen && byte_end) begin
                        tmo_cnt <= '0;
                        state   <= done_s ? ST_FLUSH : ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + TMO_W'(1);
                    if (byte_end) begin
                        if (done_s) begin
                            state <= ST_FLUSH;
                        end else if (tmo_hit) begin
                            err_q <= ERR_TIMEOUT;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (byte_end) begin
                        load_ok <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serial_cfg_loader.sv
// Top level of the serial configuration loader: done synchroniser,
// load sequencer and byte serialiser.
// Assumes: tgt_done is asynchronous; all timing parameters are in system clocks.
module serial_cfg_loader #(
    parameter int DIV_HALF    = 5,
    parameter int PULSE_CYC   = 100,
    parameter int LATENCY_CYC = 750000,
    parameter int TMO_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             start_partial,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             bs_valid,
    input  logic [7:0]       bs_data,
    input  logic             bs_last,
    output logic             bs_ready,
    output logic             tgt_prog_n,
    output logic             tgt_sclk,
    output logic             tgt_sdo,
    input  logic             tgt_done,
    output logic             busy,
    output logic             load_ok,
    output logic [1:0]       load_err,
    output logic             tgt_in_reset
);

    logic       done_s;
    logic       ld_vld;
    logic [7:0] ld_byte;
    logic       ld_rdy;
    logic       byte_end;

    cfgl_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tgt_done),
        .q     (done_s)
    );

    cfgl_sequencer #(
        .PULSE_CYC   (PULSE_CYC),
        .LATENCY_CYC (LATENCY_CYC),
        .TMO_W       (TMO_W)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .start_partial (start_partial),
        .tmo_limit     (tmo_limit),
        .done_s        (done_s),
        .bs_valid      (bs_valid),
        .bs_data       (bs_data),
        .bs_last       (bs_last),
        .bs_ready      (bs_ready),
        .ld_vld        (ld_vld),
        .ld_byte       (ld_byte),
        .ld_rdy        (ld_rdy),
        .byte_end      (byte_end),
        .prog_n        (tgt_prog_n),
        .busy          (busy),
        .load_ok       (load_ok),
        .load_err      (load_err),
        .tgt_in_reset  (tgt_in_reset)
    );

    cfgl_shifter #(.DIV_HALF(DIV_HALF)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_vld   (ld_vld),
        .ld_byte  (ld_byte),
        .ld_rdy   (ld_rdy),
        .byte_end (byte_end),
        .sclk     (tgt_sclk),
        .sdo      (tgt_sdo)
    );

endmodule

// File: rtl/serial_cfg_loader_chk.sv
// Port-level property checker for serial_cfg_loader, attached by bind.
module serial_cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       start_partial,
    input logic       bs_ready,
    input logic       tgt_prog_n,
    input logic       tgt_sclk,
    input logic       tgt_sdo,
    input logic       busy,
    input logic       load_ok,
    input logic [1:0] load_err,
    input logic       tgt_in_reset
);

    // R1: idle means pins at rest
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tgt_prog_n && !tgt_sclk && !bs_ready));

    // R2: program pin is low only during a load
    a_r2_prog_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_prog_n |-> busy);

    // R3: partial request refused without touching the pins
    a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_partial && !busy) |=> (tgt_prog_n && !busy && load_err == 2'd3));

    // R6: data holds while the serial clock is high
    a_r6_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sclk && $past(tgt_sclk)) |-> (tgt_sdo == $past(tgt_sdo)));

    // R8: success never carries an error code
    a_r8_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |-> (load_err == 2'd0));

    // R11: reset state is reported only while idle
    a_r11_report_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tgt_in_reset);

endmodule

bind serial_cfg_loader serial_cfg_loader_chk i_chk (.*);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;

    localparam int DIV_HALF = 2;
    localparam int PULSE    = 8;
    localparam int LAT      = 20;
    localparam int TMO_W    = 16;
    localparam int TMO_LIM  = 100;

    // Vector: bytes, done threshold byte, partial flag, busy poke, expected err, expected filler bytes
    typedef struct packed {
        int       n;
        int       thr;
        bit       partial;
        bit       poke;
        bit [1:0] err;
        int       dummy;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3, 3,    1'b0, 1'b0, 2'd0, 1},
        '{2, 4,    1'b0, 1'b0, 2'd0, 3},
        '{1, 1000, 1'b0, 1'b0, 2'd2, 4},
        '{2, 0,    1'b0, 1'b0, 2'd1, 0},
        '{2, 5,    1'b1, 1'b0, 2'd3, 0},
        '{5, 6,    1'b0, 1'b1, 2'd0, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic start_partial = 1'b0;
    logic [TMO_W-1:0] tmo_limit = TMO_W'(TMO_LIM);
    logic bs_valid, bs_last, bs_ready;
    logic [7:0] bs_data;
    logic tgt_prog_n, tgt_sclk, tgt_sdo, tgt_done;
    logic busy, load_ok, tgt_in_reset;
    logic [1:0] load_err;

    int checks = 0;
    int fails = 0;
    int cur_v = 0;
    int n_bytes = 0;
    int thr = 1000;
    int idx = 0;
    logic mon_clr = 1'b0;

    // Monitor state
    int cyc = 0;
    int bit_total = 0;
    int low_cnt = 0;
    int max_gap = 0;
    int min_gap = 1000000;
    int first_rise = -1;
    int rel_cyc = -1;
    int last_rise = -1;
    logic prev_sclk = 1'b0;
    logic prev_prog = 1'b1;
    logic [7:0] cap [64];

    always #2 clk = ~clk;

    function automatic logic [7:0] dat(int v, int i);
        return 8'(i * 37 + v * 11 + 165);
    endfunction

    assign bs_valid = (idx < n_bytes);
    assign bs_data  = dat(cur_v, idx);
    assign bs_last  = (idx == n_bytes - 1);
    assign tgt_done = (bit_total >= 8 * thr - 4);

    serial_cfg_loader #(
        .DIV_HALF(DIV_HALF), .PULSE_CYC(PULSE), .LATENCY_CYC(LAT), .TMO_W(TMO_W)
    ) i_serial_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_partial(start_partial),
        .tmo_limit(tmo_limit), .bs_valid(bs_valid), .bs_data(bs_data), .bs_last(bs_last),
        .bs_ready(bs_ready), .tgt_prog_n(tgt_prog_n), .tgt_sclk(tgt_sclk), .tgt_sdo(tgt_sdo),
        .tgt_done(tgt_done), .busy(busy), .load_ok(load_ok), .load_err(load_err),
        .tgt_in_reset(tgt_in_reset)
    );

    // Stream source: advance on each accepted byte
    always @(posedge clk) begin
        if (mon_clr)                    idx <= 0;
        else if (bs_valid && bs_ready) idx <= idx + 1;
    end

    // Pin monitor: pulse width, release time, clock spacing, captured bits
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            bit_total = 0; low_cnt = 0; max_gap = 0; min_gap = 1000000;
            first_rise = -1; rel_cyc = -1; last_rise = -1;
        end else begin
            if (!tgt_prog_n) low_cnt = low_cnt + 1;
            if (tgt_prog_n && !prev_prog) rel_cyc = cyc;
            if (tgt_sclk && !prev_sclk) begin
                if (first_rise < 0) first_rise = cyc;
                if (last_rise >= 0) begin
                    if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
                    if (cyc - last_rise < min_gap) min_gap = cyc - last_rise;
                end
                last_rise = cyc;
                if (bit_total < 512) cap[bit_total / 8] = {cap[bit_total / 8][6:0], tgt_sdo};
                bit_total = bit_total + 1;
            end
        end
        prev_sclk = tgt_sclk;
        prev_prog = tgt_prog_n;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(vec_t t);
        if (t.poke)        return "R12";
        if (t.err == 2'd3) return "R3";
        if (t.err == 2'd1) return "R4";
        if (t.err == 2'd2) return "R10";
        if (t.dummy == 1)  return "R8";
        return "R9";
    endfunction

    task automatic wait_bits(input int nb);
        for (int k = 0; k < 5000 && bit_total < nb; k++) step();
    endtask

    task automatic run_vec(input int v);
        vec_t t;
        int exp_bits;
        int bad;
        string tg;
        t = VECS[v];
        tg = tag_of(t);
        exp_bits = (t.n + t.dummy) * 8;
        if (t.err == 2'd1 || t.err == 2'd3) exp_bits = 0;
        cur_v = v; n_bytes = t.n; thr = t.thr;
        mon_clr = 1'b1; step(); mon_clr = 1'b0;
        repeat (5) step();
        start_req = 1'b1; start_partial = t.partial; step();
        start_req = 1'b0; start_partial = 1'b0;
        if (t.poke) begin
            wait_bits(4);
            start_req = 1'b1; start_partial = 1'b1; step();
            start_req = 1'b0; start_partial = 1'b0;
        end
        if (exp_bits > 0) begin
            wait_bits(1);
            chk("R11 busy report", tgt_in_reset, 0);
        end
        for (int k = 0; k < 20000 && busy; k++) step();
        step();
        chk({tg, " result code"}, load_err, t.err);
        chk({tg, " ok flag"}, load_ok, (t.err == 2'd0) ? 1 : 0);
        chk({tg, " serial bits"}, bit_total, exp_bits);
        chk("R2 pulse width", low_cnt, t.partial ? 0 : PULSE);
        if (exp_bits > 0) begin
            chk("R5 latency", (first_rise - rel_cyc >= LAT) ? 1 : 0, 1);
            chk("R7 max spacing", max_gap, 2 * DIV_HALF);
            chk("R7 min spacing", min_gap, 2 * DIV_HALF);
            bad = 0;
            for (int b = 0; b < t.n + t.dummy; b++) begin
                if (cap[b] != ((b < t.n) ? dat(v, b) : 8'hFF)) begin
                    if (bad == 0)
                        $display("FAIL R6 byte %0d: actual %0h expected %0h", b, cap[b],
                                 (b < t.n) ? dat(v, b) : 8'hFF);
                    bad++;
                end
            end
            checks++;
            if (bad != 0) fails++;
        end
    endtask

    task automatic run_all();
        // R1: reset state
        repeat (5) step();
        rst_n = 1'b1;
        step();
        chk("R1 prog_n", tgt_prog_n, 1);
        chk("R1 sclk", tgt_sclk, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ok", load_ok, 0);
        chk("R1 err", load_err, 0);
        chk("R1 ready", bs_ready, 0);

        // Vector table
        for (int v = 0; v < NV; v++) run_vec(v);

        // R11: idle reporting follows done
        mon_clr = 1'b1; thr = 1000; n_bytes = 0; step(); mon_clr = 1'b0;
        repeat (4) step();
        chk("R11 idle done low", tgt_in_reset, 1);
        thr = 0;
        repeat (4) step();
        chk("R11 idle done high", tgt_in_reset, 0);

        // R1: reset in the middle of a load
        thr = 1000; cur_v = 5; n_bytes = 5;
        mon_clr = 1'b1; step(); mon_clr = 1'b0;
        repeat (5) step();
        start_req = 1'b1; step(); start_req = 1'b0;
        wait_bits(10);
        rst_n = 1'b0; step();
        chk("R1 mid-load prog_n", tgt_prog_n, 1);
        chk("R1 mid-load sclk", tgt_sclk, 0);
        chk("R1 mid-load busy", busy, 0);
        chk("R1 mid-load err", load_err, 0);
        rst_n = 1'b1; n_bytes = 0;
        repeat (3) step();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule